// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides when an outside master may take over the external memory bus. An external agent raises a hold request. The block brings that asynchronous request into its clock domain. It then waits until the local bus controller reaches a point where the bus can safely be given away. At that point it raises a grant flag and drops the enable that drives the address/data lines and the control strobes. The whole function is switched on and off by a single enable input. While it is off, requests are ignored.

While the bus is given away, the block signals the outside master through a separate request-back output whenever the local controller has an external access waiting. When the outside master withdraws its request, the grant is removed, the bus drivers are enabled again, and the waiting access may start on the next clock. An access that is already in progress is never cut short. A byte-wide bus that moves a 16-bit word in two halves counts as one access, so the bus is released only after the second half. When no access is in progress, the grant follows recognition of the request after a single clock.

Top module: `hold_arbiter`

## Requirements
- R1: While reset is high and on the clock after it, grant_o is 0, drv_en_o is 1, want_bus_o is 0 and start_ok_o is 1.
- R2: With arbitration enabled and no access in progress, a request that rises before clock edge k gives grant_o high after edge k+SYNC_STAGES; a change of hold_req_i affects nothing before SYNC_STAGES edges have passed.
- R3: While arb_en_i is 0, hold_req_i has no effect: grant_o stays 0, drv_en_o stays 1, want_bus_o stays 0 and start_ok_o stays 1.
- R4: grant_o never rises while an access is in progress (acc_busy_i high) unless that clock is the end of the access.
- R5: A clock with acc_done_i=1 and acc_more_i=1 (end of the first half of a split word) is not an end of access and does not allow the grant.
- R6: A recognised request that meets an access in progress gives grant_o high on the edge after the first clock with acc_done_i=1 and acc_more_i=0.
- R7: drv_en_o is always the complement of grant_o: the bus drivers are off exactly while the bus is granted.
- R8: While the grant holds, want_bus_o equals acc_pend_i of the previous clock; want_bus_o is 0 whenever grant_o is 0.
- R9: When the synchronised request falls, or arb_en_i falls, during the grant, grant_o and want_bus_o drop on the next edge and start_ok_o is 1 in the following clock.
- R10: start_ok_o is 0 while the grant holds, while an access is being waited out, and in any clock where an enabled request is recognised; a recognised request withdrawn while waiting returns control without a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_en_i | input | 1 | Enables the hold function |
| hold_req_i | input | 1 | Asynchronous request from the outside master |
| acc_busy_i | input | 1 | Local controller has an external access in progress |
| acc_done_i | input | 1 | This clock ends a bus transfer |
| acc_more_i | input | 1 | The ending transfer is the first half of a split word |
| acc_pend_i | input | 1 | Local controller has an external access waiting |
| grant_o | output | 1 | Bus is granted to the outside master |
| drv_en_o | output | 1 | Drive enable for address/data and strobes |
| want_bus_o | output | 1 | Request-back to the outside master during the grant |
| start_ok_o | output | 1 | Local controller may start a new external access |

## Verification
The bench builds the block with the default SYNC_STAGES of 2, so the recognition delay it checks is two edges plus one for the state register. The behavioural model takes its synchroniser depth from the same parameter. Its scenarios cover an idle grant, long single accesses, split-word accesses where the first-half end must be passed over, a request withdrawn while an access is waited out, and the enable dropped in the middle of a grant.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

    typedef enum logic [1:0] {
        ARB_OWN   = 2'd0,
        ARB_DRAIN = 2'd1,
        ARB_GRANT = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic more;
        logic pend;
    } acc_stat_t;

    function automatic logic acc_boundary(acc_stat_t s);
        return s.done && !s.more;
    endfunction

    function automatic logic bus_free(acc_stat_t s);
        return !s.busy || acc_boundary(s);
    endfunction

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= 1'b0;
                    else     stg[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= 1'b0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import hold_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       req_s_i,
    input  acc_stat_t  stat_i,
    output arb_state_e state_o,
    output arb_state_e next_o
);
    arb_state_e st;

    always_comb begin
        next_o = st;
        if (!en_i) begin
            next_o = ARB_OWN;
        end else begin
            case (st)
                ARB_OWN: begin
                    if (req_s_i)
                        next_o = bus_free(stat_i) ? ARB_GRANT : ARB_DRAIN;
                end
                ARB_DRAIN: begin
                    if (!req_s_i)                  next_o = ARB_OWN;
                    else if (acc_boundary(stat_i)) next_o = ARB_GRANT;
                end
                ARB_GRANT: begin
                    if (!req_s_i) next_o = ARB_OWN;
                end
                default: next_o = ARB_OWN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ARB_OWN;
        else     st <= next_o;
    end

    assign state_o = st;
endmodule

// File: rtl/hold_outs.sv
module hold_outs
    import hold_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       req_s_i,
    input  logic       pend_i,
    input  arb_state_e state_i,
    input  arb_state_e next_i,
    output logic       grant_o,
    output logic       drv_en_o,
    output logic       want_o,
    output logic       start_ok_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o  <= 1'b0;
            drv_en_o <= 1'b1;
            want_o   <= 1'b0;
        end else begin
            grant_o  <= (next_i == ARB_GRANT);
            drv_en_o <= (next_i != ARB_GRANT);
            want_o   <= (next_i == ARB_GRANT) && pend_i;
        end
    end

    assign start_ok_o = (state_i == ARB_OWN) && !(en_i && req_s_i);
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
    import hold_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arb_en_i,
    input  logic hold_req_i,
    input  logic acc_busy_i,
    input  logic acc_done_i,
    input  logic acc_more_i,
    input  logic acc_pend_i,
    output logic grant_o,
    output logic drv_en_o,
    output logic want_bus_o,
    output logic start_ok_o
);
    logic       req_s;
    acc_stat_t  stat;
    arb_state_e state;
    arb_state_e nxt;

    assign stat = '{busy: acc_busy_i, done: acc_done_i, more: acc_more_i, pend: acc_pend_i};

    hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (hold_req_i),
        .q_o (req_s)
    );

    hold_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en_i    (arb_en_i),
        .req_s_i (req_s),
        .stat_i  (stat),
        .state_o (state),
        .next_o  (nxt)
    );

    hold_outs u_outs (
        .clk        (clk),
        .rst        (rst),
        .en_i       (arb_en_i),
        .req_s_i    (req_s),
        .pend_i     (acc_pend_i),
        .state_i    (state),
        .next_i     (nxt),
        .grant_o    (grant_o),
        .drv_en_o   (drv_en_o),
        .want_o     (want_bus_o),
        .start_ok_o (start_ok_o)
    );

    AST_OFF_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        !arb_en_i |=> !grant_o); // R3

    AST_NO_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
        (!grant_o && acc_busy_i && !(acc_done_i && !acc_more_i)) |=> !grant_o); // R4

    AST_SPLIT_HALF: assert property (@(posedge clk) disable iff (rst)
        (!grant_o && acc_busy_i && acc_done_i && acc_more_i) |=> !grant_o); // R5

    AST_DRV_COMPL: assert property (@(posedge clk) disable iff (rst)
        drv_en_o != grant_o); // R7

    AST_WANT_IN_GRANT: assert property (@(posedge clk) disable iff (rst)
        want_bus_o |-> grant_o); // R8

    AST_START_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> !start_ok_o); // R10

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state != 2'd3); // R10
endmodule

// File: tb/hold_arbiter_tb.sv
module hold_arbiter_tb_top;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, hreq = 1'b0, busy = 1'b0, done = 1'b0, more = 1'b0, pend = 1'b0;
    logic grant, drv_en, want, start_ok;

    int checks = 0;
    int fails = 0;
    string tag = "R1";

    // behavioural reference
    logic [SYNC-1:0] sq;
    int   mode;          // 0 local, 1 waiting out an access, 2 granted
    logic e_grant, e_want;

    always #2.5 clk = ~clk;

    hold_arbiter #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst(rst), .arb_en_i(en), .hold_req_i(hreq),
        .acc_busy_i(busy), .acc_done_i(done), .acc_more_i(more), .acc_pend_i(pend),
        .grant_o(grant), .drv_en_o(drv_en), .want_bus_o(want), .start_ok_o(start_ok)
    );

    always @(posedge clk) begin
        if (rst) begin
            sq = '0; mode = 0; e_grant = 1'b0; e_want = 1'b0;
        end else begin
            automatic logic rs = sq[SYNC-1];
            automatic int nm = mode;
            automatic logic edge_ok = done && !more;
            sq = {sq[SYNC-2:0], hreq};
            if (!en) nm = 0;
            else if (mode == 0) begin
                if (rs) nm = (!busy || edge_ok) ? 2 : 1;
            end else if (mode == 1) begin
                if (!rs) nm = 0; else if (edge_ok) nm = 2;
            end else begin
                if (!rs) nm = 0;
            end
            mode = nm;
            e_grant = (nm == 2);
            e_want = (nm == 2) && pend;
        end
    end

    task automatic chk(string name, logic act, logic exp, string t);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", t, name, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("grant", grant, e_grant, tag);
            chk("drv_en", drv_en, !e_grant, "R7");
            chk("want_bus", want, e_want, "R8");
            chk("start_ok", start_ok, (mode == 0) && !(en && sq[SYNC-1]), "R10");
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(logic b, logic d, logic m);
        busy = b; done = d; more = m;
    endtask

    initial begin : wd
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        tick(3);
        chk("grant", grant, 1'b0, "R1");
        chk("drv_en", drv_en, 1'b1, "R1");
        chk("want_bus", want, 1'b0, "R1");
        chk("start_ok", start_ok, 1'b1, "R1");
        rst = 1'b0;
        tick(1);
        chk("grant", grant, 1'b0, "R1");
        chk("drv_en", drv_en, 1'b1, "R1");

        // R3 disabled: request ignored
        tag = "R3";
        hreq = 1'b1; pend = 1'b1;
        tick(8);
        chk("grant", grant, 1'b0, "R3");
        chk("want_bus", want, 1'b0, "R3");
        chk("start_ok", start_ok, 1'b1, "R3");
        hreq = 1'b0; pend = 1'b0;
        tick(4);

        // R2 idle grant latency: SYNC+1 edges
        tag = "R2";
        en = 1'b1;
        tick(2);
        hreq = 1'b1;
        for (int i = 1; i <= SYNC; i++) begin
            tick(1);
            chk("grant early", grant, 1'b0, "R2");
        end
        tick(1);
        chk("grant on time", grant, 1'b1, "R2");

        // R8 request-back follows pending access
        tag = "R8";
        pend = 1'b1; tick(1);
        chk("want_bus", want, 1'b1, "R8");
        pend = 1'b0; tick(1);
        chk("want_bus low", want, 1'b0, "R8");
        pend = 1'b1; tick(2);

        // R9 release on withdrawn request
        tag = "R9";
        hreq = 1'b0;
        tick(SYNC + 1);
        chk("grant released", grant, 1'b0, "R9");
        chk("want_bus released", want, 1'b0, "R9");
        chk("start_ok after release", start_ok, 1'b1, "R9");
        pend = 1'b0;
        tick(3);

        // R4/R6 long access waited out
        tag = "R4";
        drive(1'b1, 1'b0, 1'b0);
        hreq = 1'b1;
        tick(SYNC + 4);
        chk("grant mid access", grant, 1'b0, "R4");
        chk("start_ok waiting", start_ok, 1'b0, "R10");
        tag = "R6";
        drive(1'b1, 1'b1, 1'b0);
        tick(1);
        drive(1'b0, 1'b0, 1'b0);
        chk("grant at boundary", grant, 1'b1, "R6");
        tick(2);
        hreq = 1'b0;
        tick(SYNC + 2);

        // R5 split word: first-half end is not a boundary
        tag = "R5";
        drive(1'b1, 1'b0, 1'b0);
        hreq = 1'b1;
        tick(SYNC + 2);
        drive(1'b1, 1'b1, 1'b1);
        tick(1);
        chk("grant after first half", grant, 1'b0, "R5");
        drive(1'b1, 1'b0, 1'b0);
        tick(2);
        chk("grant in second half", grant, 1'b0, "R5");
        drive(1'b1, 1'b1, 1'b0);
        tick(1);
        drive(1'b0, 1'b0, 1'b0);
        chk("grant after second half", grant, 1'b1, "R6");
        hreq = 1'b0;
        tick(SYNC + 2);

        // R10 request withdrawn while waiting: no grant
        tag = "R10";
        drive(1'b1, 1'b0, 1'b0);
        hreq = 1'b1;
        tick(SYNC + 2);
        hreq = 1'b0;
        tick(SYNC + 2);
        drive(1'b1, 1'b1, 1'b0);
        tick(1);
        drive(1'b0, 1'b0, 1'b0);
        chk("no grant after withdraw", grant, 1'b0, "R10");
        chk("start_ok back", start_ok, 1'b1, "R10");
        tick(2);

        // R9 enable dropped during grant
        tag = "R9";
        hreq = 1'b1; pend = 1'b1;
        tick(SYNC + 2);
        chk("grant before disable", grant, 1'b1, "R9");
        en = 1'b0;
        tick(1);
        chk("grant after disable", grant, 1'b0, "R9");
        chk("want after disable", want, 1'b0, "R9");
        chk("start_ok after disable", start_ok, 1'b1, "R9");
        tick(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule